// File: doc/BRIEF.md
# Cut-Through Cell-to-Frame Reassembler

This block sits between a byte stream that carries fixed-size cell payloads and a byte-wide frame transmitter that runs faster than the input. A packet arrives as a train of back-to-back cells of `CELL_BYTES` payload bytes each. The block keeps only the first `PKT_LEN` bytes of the train, because the rest is padding in the final cell. It writes those bytes into a dual-port byte buffer.

The output does not wait for the whole packet. Once `START_LVL` packet bytes are stored, the block sends a fixed eight-byte lead-in of seven 0x55 bytes and one 0xD5 byte. The packet bytes then follow one per output tick, with no gaps. The threshold is chosen so that the slower input stays ahead of the faster output read pointer. If the threshold is too low, the output reaches a byte that has not been written yet, and the block latches a sticky error flag.

Both directions share a single clock. The input rate is set by `in_valid`, which drops low during framing-overhead gaps. The output rate is set by the `out_tick` enable. After each frame the output stays silent for `IFG` ticks, and no new packet is accepted until that silence is over.

Top module: `cfr_reassembler`

## Requirements
- R1: While reset is held and directly after it, `out_valid` and `underrun` are 0.
- R2: Each frame starts with eight output bytes: 0x55 seven times, then 0xD5.
- R3: After the lead-in, exactly `PKT_LEN` bytes follow. They equal the first `PKT_LEN` payload bytes of the train, in arrival order. One byte goes out per `out_tick`, with no tick skipped.
- R4: Train bytes past position `PKT_LEN`, up to `ceil(PKT_LEN/CELL_BYTES)*CELL_BYTES`, are never output. A frame is exactly `PKT_LEN+8` bytes.
- R5: The first lead-in byte is not emitted before at least `START_LVL` packet bytes (capped at `PKT_LEN`) have been accepted.
- R6: `underrun` is set when the output reaches a packet byte not yet written, and it then stays set until reset. At an adequate threshold it never sets.
- R7: `out_valid` is high for one cycle after each `out_tick` on which a byte is sent, and never at any other time.
- R8: After the last packet byte, at least `IFG` ticks pass before the next frame. A start flag that arrives while a frame is in progress or in this gap is ignored, and its whole train is discarded.
- R9: A byte with `in_valid` set that is not part of an accepted train is discarded and causes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both rates |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input payload byte present this cycle |
| in_sop | input | 1 | With in_valid: first payload byte of a packet's first cell |
| in_data | input | 8 | Input payload byte |
| out_tick | input | 1 | Output byte-rate enable |
| out_valid | output | 1 | Output byte present this cycle |
| out_data | output | 8 | Output byte |
| underrun | output | 1 | Sticky flag: output overtook the write side |

## Verification
The hardest state to reach is the boundary where the read pointer nearly catches the write pointer. Reaching it needs a faster output paired with an input cadence that has idle slots. The bench sweeps several input duty patterns (five to eight bytes in eight cycles with a tick every cycle, and three in eight with a tick every other cycle) against one safe threshold. It drives a second instance with a deliberately low threshold from the same stimulus, so the flag is seen both clear and set. The rejected-start case is reached by timing a new start flag a few cycles after the last frame byte, inside the gap.

// File: rtl/cfr_pkg.sv
package cfr_pkg;
  typedef enum logic [1:0] {
    TX_IDLE,
    TX_LEAD,
    TX_DATA,
    TX_GAP
  } tx_state_e;

  localparam int unsigned LEAD_LEN = 8;
  localparam logic [7:0] LEAD_FILL = 8'h55;
  localparam logic [7:0] LEAD_MARK = 8'hD5;
endpackage

// File: rtl/cfr_byte_ram.sv
module cfr_byte_ram #(
  parameter int unsigned DEPTH = 2048,
  parameter int unsigned AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[wr_addr] <= wr_data;
    end
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/cfr_cell_rx.sv
module cfr_cell_rx #(
  parameter int unsigned PKT_LEN    = 1518,
  parameter int unsigned CELL_BYTES = 48,
  parameter int unsigned AW         = 11,
  parameter int unsigned CW         = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          in_sop,
  input  logic [7:0]    in_data,
  input  logic          tx_idle,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic [CW-1:0] wr_cnt,
  output logic          pkt_start
);
  localparam int unsigned CELLS = (PKT_LEN + CELL_BYTES - 1) / CELL_BYTES;
  localparam int unsigned TRAIN = CELLS * CELL_BYTES;
  localparam logic [CW-1:0] LEN_C  = CW'(PKT_LEN);
  localparam logic [CW-1:0] LAST_C = CW'(TRAIN - 1);

  logic          busy_q, busy_n;
  logic [CW-1:0] seen_q, seen_n;
  logic [CW-1:0] wcnt_q, wcnt_n;
  logic          accept;

  always_comb begin
    accept  = in_valid & in_sop & ~busy_q & tx_idle;
    busy_n  = busy_q;
    seen_n  = seen_q;
    wcnt_n  = wcnt_q;
    wr_en   = 1'b0;
    wr_addr = AW'(seen_q);
    wr_data = in_data;
    if (accept) begin
      busy_n  = (TRAIN > 1);
      seen_n  = CW'(1);
      wcnt_n  = CW'(1);
      wr_en   = 1'b1;
      wr_addr = '0;
    end else if (busy_q && in_valid) begin
      seen_n = seen_q + CW'(1);
      if (seen_q < LEN_C) begin
        wr_en  = 1'b1;
        wcnt_n = wcnt_q + CW'(1);
      end
      if (seen_q == LAST_C) begin
        busy_n = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      seen_q <= '0;
      wcnt_q <= '0;
    end else begin
      busy_q <= busy_n;
      seen_q <= seen_n;
      wcnt_q <= wcnt_n;
    end
  end

  assign wr_cnt    = wcnt_q;
  assign pkt_start = accept;

  AST_WCNT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    wcnt_q <= LEN_C); // R4
  AST_START_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_sop && !busy_q && !tx_idle) |=> !busy_q); // R8
  AST_STRAY_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && !(in_valid && in_sop)) |=> $stable(wcnt_q)); // R9
endmodule

// File: rtl/cfr_frame_tx.sv
module cfr_frame_tx
  import cfr_pkg::*;
#(
  parameter int unsigned PKT_LEN   = 1518,
  parameter int unsigned START_LVL = 600,
  parameter int unsigned IFG       = 12,
  parameter int unsigned AW        = 11,
  parameter int unsigned CW        = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          pkt_start,
  input  logic [CW-1:0] wr_cnt,
  output logic [AW-1:0] rd_addr,
  input  logic [7:0]    rd_data,
  output logic          out_valid,
  output logic [7:0]    out_data,
  output logic          underrun,
  output logic          tx_idle
);
  localparam int unsigned KMAX   = (PKT_LEN > IFG) ? PKT_LEN : IFG;
  localparam int unsigned KW     = $clog2(KMAX + LEAD_LEN);
  localparam int unsigned GO_LVL = (START_LVL > PKT_LEN) ? PKT_LEN :
                                   ((START_LVL < 1) ? 1 : START_LVL);
  localparam logic [KW-1:0] LEAD_END = KW'(LEAD_LEN - 1);
  localparam logic [KW-1:0] DATA_END = KW'(PKT_LEN - 1);
  localparam logic [KW-1:0] GAP_END  = KW'(IFG - 1);

  tx_state_e     st_q, st_n;
  logic [KW-1:0] cnt_q, cnt_n;
  logic          armed_q, armed_n;
  logic          vld_q, vld_n;
  logic [7:0]    dat_q, dat_n;
  logic          unr_q, unr_n;

  always_comb begin
    st_n    = st_q;
    cnt_n   = cnt_q;
    armed_n = armed_q | pkt_start;
    vld_n   = 1'b0;
    dat_n   = dat_q;
    unr_n   = unr_q;
    unique case (st_q)
      TX_IDLE: begin
        if (armed_q && tick && (32'(wr_cnt) >= GO_LVL)) begin
          st_n    = TX_LEAD;
          cnt_n   = KW'(1);
          armed_n = 1'b0;
          vld_n   = 1'b1;
          dat_n   = LEAD_FILL;
        end
      end
      TX_LEAD: begin
        if (tick) begin
          vld_n = 1'b1;
          if (cnt_q == LEAD_END) begin
            dat_n = LEAD_MARK;
            st_n  = TX_DATA;
            cnt_n = '0;
          end else begin
            dat_n = LEAD_FILL;
            cnt_n = cnt_q + KW'(1);
          end
        end
      end
      TX_DATA: begin
        if (tick) begin
          vld_n = 1'b1;
          dat_n = rd_data;
          if (32'(cnt_q) >= 32'(wr_cnt)) begin
            unr_n = 1'b1;
          end
          if (cnt_q == DATA_END) begin
            st_n  = TX_GAP;
            cnt_n = '0;
          end else begin
            cnt_n = cnt_q + KW'(1);
          end
        end
      end
      TX_GAP: begin
        if (tick) begin
          if (cnt_q == GAP_END) begin
            st_n  = TX_IDLE;
            cnt_n = '0;
          end else begin
            cnt_n = cnt_q + KW'(1);
          end
        end
      end
      default: begin
        st_n = TX_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= TX_IDLE;
      cnt_q   <= '0;
      armed_q <= 1'b0;
      vld_q   <= 1'b0;
      dat_q   <= '0;
      unr_q   <= 1'b0;
    end else begin
      st_q    <= st_n;
      cnt_q   <= cnt_n;
      armed_q <= armed_n;
      vld_q   <= vld_n;
      dat_q   <= dat_n;
      unr_q   <= unr_n;
    end
  end

  assign rd_addr   = AW'(cnt_q);
  assign out_valid = vld_q;
  assign out_data  = dat_q;
  assign underrun  = unr_q;
  assign tx_idle   = (st_q == TX_IDLE) && !armed_q;

  AST_GO_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == TX_LEAD && $past(st_q) == TX_IDLE) |-> (32'($past(wr_cnt)) >= GO_LVL)); // R5
  AST_UNDERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    unr_q |=> unr_q); // R6
  AST_VALID_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |-> $past(tick)); // R7
  AST_GAP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == TX_GAP && $past(st_q) == TX_GAP) |-> !vld_q); // R8
endmodule

// File: rtl/cfr_reassembler.sv
module cfr_reassembler #(
  parameter int unsigned PKT_LEN    = 1518,
  parameter int unsigned CELL_BYTES = 48,
  parameter int unsigned DEPTH      = 2048,
  parameter int unsigned START_LVL  = 600,
  parameter int unsigned IFG        = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic       in_sop,
  input  logic [7:0] in_data,
  input  logic       out_tick,
  output logic       out_valid,
  output logic [7:0] out_data,
  output logic       underrun
);
  localparam int unsigned CELLS = (PKT_LEN + CELL_BYTES - 1) / CELL_BYTES;
  localparam int unsigned TRAIN = CELLS * CELL_BYTES;
  localparam int unsigned AW    = $clog2(DEPTH);
  localparam int unsigned CW    = $clog2(TRAIN + 1);

  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic [7:0]    wr_data;
  logic [CW-1:0] wr_cnt;
  logic          pkt_start;
  logic          tx_idle;
  logic [AW-1:0] rd_addr;
  logic [7:0]    rd_data;

  cfr_cell_rx #(
    .PKT_LEN(PKT_LEN), .CELL_BYTES(CELL_BYTES), .AW(AW), .CW(CW)
  ) u_rx (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
    .in_data(in_data), .tx_idle(tx_idle), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_cnt(wr_cnt),
    .pkt_start(pkt_start)
  );

  cfr_byte_ram #(.DEPTH(DEPTH), .AW(AW)) u_ram (
    .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  cfr_frame_tx #(
    .PKT_LEN(PKT_LEN), .START_LVL(START_LVL), .IFG(IFG), .AW(AW), .CW(CW)
  ) u_tx (
    .clk(clk), .rst_n(rst_n), .tick(out_tick), .pkt_start(pkt_start),
    .wr_cnt(wr_cnt), .rd_addr(rd_addr), .rd_data(rd_data),
    .out_valid(out_valid), .out_data(out_data), .underrun(underrun),
    .tx_idle(tx_idle)
  );

  AST_NO_OUT_IN_RESET_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(out_tick)); // R1
endmodule

// File: tb/tb_cfr_reassembler.sv
module tb_cfr_reassembler;
  localparam int L     = 100;
  localparam int CB    = 48;
  localparam int TRAIN = 144;
  localparam int DEP   = 256;
  localparam int GOOD  = 50;
  localparam int LOW   = 5;
  localparam int FRAME = L + 8;

  logic clk = 1'b0;
  logic rst_n;
  logic in_valid, in_sop, out_tick;
  logic [7:0] in_data;
  logic out_valid, underrun, out_valid_lo, underrun_lo;
  logic [7:0] out_data, out_data_lo;

  always #5 clk = ~clk;

  cfr_reassembler #(.PKT_LEN(L), .CELL_BYTES(CB), .DEPTH(DEP), .START_LVL(GOOD), .IFG(12)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop), .in_data(in_data),
    .out_tick(out_tick), .out_valid(out_valid), .out_data(out_data), .underrun(underrun));

  cfr_reassembler #(.PKT_LEN(L), .CELL_BYTES(CB), .DEPTH(DEP), .START_LVL(LOW), .IFG(12)) dut_low (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop), .in_data(in_data),
    .out_tick(out_tick), .out_valid(out_valid_lo), .out_data(out_data_lo), .underrun(underrun_lo));

  int tests = 0, fails = 0, cyc = 0, fed = 0, tot = 0;
  int tick_per = 1, tick_ph = 0;
  logic [7:0] ob [0:2047];
  int oc [0:2047];
  int ofed [0:2047];

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    out_tick = (tick_ph == 0);
    tick_ph  = (tick_ph + 1 >= tick_per) ? 0 : tick_ph + 1;
  end

  always @(negedge clk) begin
    if (rst_n === 1'b1 && out_valid === 1'b1 && tot < 2048) begin
      ob[tot] = out_data; oc[tot] = cyc; ofed[tot] = fed; tot++;
    end
  end

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  function automatic logic [7:0] exp_byte(input int seed, input int j);
    if (j < L) return 8'((seed + 7 * j) & 255);
    return 8'((8'hE0 ^ j) & 255);
  endfunction

  task automatic send_train(input int seed, input int k, input bit with_sop);
    int j = 0;
    int slot = 0;
    while (j < TRAIN) begin
      @(negedge clk);
      if (slot < k) begin
        in_valid = 1'b1; in_sop = (j == 0) && with_sop; in_data = exp_byte(seed, j); j++;
      end else begin
        in_valid = 1'b0; in_sop = 1'b0;
      end
      slot = (slot + 1) % 8;
      @(posedge clk);
      if (in_valid) fed++;
    end
    @(negedge clk);
    in_valid = 1'b0; in_sop = 1'b0;
  endtask

  task automatic wait_frame(input int base);
    int n = 0;
    while (tot < base + FRAME && n < 3000) begin @(negedge clk); n++; end
  endtask

  task automatic run_frame(input int seed, input int k, input int per);
    int base, fed0, bad, badi;
    tick_per = per;
    repeat (4) @(negedge clk);
    base = tot; fed0 = fed;
    send_train(seed, k, 1'b1);
    wait_frame(base);
    repeat (40) @(negedge clk);
    check(tot - base == FRAME, "R4", "frame length", tot - base, FRAME);
    if (tot - base >= FRAME) begin
      check(ofed[base] - fed0 >= GOOD, "R5", "bytes in before lead-in", ofed[base] - fed0, GOOD);
      bad = 0; badi = 0;
      for (int i = 0; i < 8; i++) begin
        if (ob[base + i] !== ((i == 7) ? 8'hD5 : 8'h55) && bad == 0) begin bad = 1; badi = i; end
      end
      check(bad == 0, "R2", "lead-in byte", int'(ob[base + badi]), (badi == 7) ? 32'hD5 : 32'h55);
      bad = 0; badi = 0;
      for (int i = 0; i < L; i++) begin
        if (ob[base + 8 + i] !== exp_byte(seed, i) && bad == 0) begin bad = 1; badi = i; end
      end
      check(bad == 0, "R3", "packet byte", int'(ob[base + 8 + badi]), int'(exp_byte(seed, badi)));
      check(oc[base + FRAME - 1] - oc[base] == (FRAME - 1) * per, "R7", "frame span in cycles",
            oc[base + FRAME - 1] - oc[base], (FRAME - 1) * per);
    end
    check(underrun == 1'b0, "R6", "underrun at safe threshold", int'(underrun), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int base;
    out_tick = 1'b0; in_valid = 1'b0; in_sop = 1'b0; in_data = 8'h00;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(out_valid === 1'b0, "R1", "out_valid in reset", int'(out_valid), 0);
    check(underrun === 1'b0, "R1", "underrun in reset", int'(underrun), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(out_valid === 1'b0 && underrun === 1'b0, "R1", "outputs after reset",
          int'({out_valid, underrun}), 0);

    // R9: bytes with no start flag are dropped
    for (int i = 0; i < 20; i++) begin
      @(negedge clk); in_valid = 1'b1; in_sop = 1'b0; in_data = 8'(i);
    end
    @(negedge clk); in_valid = 1'b0;
    repeat (60) @(negedge clk);
    check(tot == 0, "R9", "output after stray bytes", tot, 0);

    // sweep of input duty and output tick rate
    run_frame(3, 5, 1);
    check(underrun_lo == 1'b1, "R6", "underrun at low threshold", int'(underrun_lo), 1);
    run_frame(17, 6, 1);
    run_frame(40, 7, 1);
    run_frame(91, 8, 1);
    run_frame(128, 3, 2);
    check(underrun_lo == 1'b1, "R6", "underrun stays set", int'(underrun_lo), 1);

    // R8: start flag inside the inter-frame gap is ignored
    tick_per = 1;
    repeat (4) @(negedge clk);
    base = tot;
    send_train(200, 8, 1'b1);
    wait_frame(base);
    repeat (3) @(negedge clk);
    send_train(77, 8, 1'b1);
    repeat (200) @(negedge clk);
    check(tot - base == FRAME, "R8", "bytes after rejected start", tot - base, FRAME);

    run_frame(5, 6, 1);
    finish_run();
  end
endmodule